// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Port with Address Flag

This block is a full-duplex asynchronous serial port. A transmitter serialises bytes handed over through a valid/ready handshake. A receiver rebuilds characters from an incoming line and reports each one with a single-cycle valid strobe. Each report carries three flags: parity error, framing error and address.

The frame shape is set by static configuration inputs:
- the character length, from 5 to 8 bits;
- the parity kind, which is none, even or odd;
- the length of the stop period, which is one, one and a half or two bit times;
- an address mode for multidrop buses. In this mode a ninth bit after the data marks the character as an address, and this bit replaces the parity bit.

Both directions run from one shared tick at sixteen times the bit rate. The tick comes from a divisor made of an integer part and a fraction in eighths of a clock. This gives bit rates that a whole-number divider cannot reach. The configuration is captured at the start of each character, so changing it between characters is safe.

Top module: `muart_core`

## Requirements
- R1: After reset, `tx_line` is high, `tx_ready` is high and `rx_valid` is low. `tx_line` is high whenever the transmitter is idle.
- R2: A transmitted character starts with one low start bit. The data bits follow, least significant bit first. `cfg_len` sets the count: 00=5, 01=6, 10=7, 11=8 bits.
- R3: `cfg_parity` selects 00=none, 01=even, 10=odd (11 acts as none). With even or odd parity, and address mode off, one parity bit follows the data. Even parity makes the number of ones across the data bits and this bit even. Odd parity makes it odd.
- R4: The stop period is high and lasts 16, 24 or 32 oversample ticks for `cfg_stop` = 00, 01 or 10 (11 acts as 10). `tx_ready` is low from the start bit until the stop period ends.
- R5: When `cfg_addr_mode` is 1, the transmitter sends `tx_addr` as a ninth bit after the data, in place of any parity bit.
- R6: The oversample tick period averages `baud_int + baud_frac/8` clocks. Each tick gap is `baud_int` or `baud_int`+1 clocks, and `baud_int`=0 acts as 1. One bit lasts 16 ticks.
- R7: The receiver delivers each character on `rx_data`, zero-extended above the configured length.
- R8: With parity on and address mode off, `rx_par_err` is set when the received parity bit does not match the parity of the received data. With parity off it is clear.
- R9: The receiver samples only the first stop bit, at its centre. `rx_frame_err` is set when that sample is low.
- R10: In address mode the received ninth bit is reported on `rx_addr_flag`, and `rx_par_err` stays clear. Outside address mode `rx_addr_flag` is 0.
- R11: A low pulse on `rx_line` that is shorter than half a bit is not taken as a start bit, and no character is reported.
- R12: `rx_valid` pulses high for exactly one clock per received character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 2 | Character length code (5 + value bits) |
| cfg_parity | input | 2 | Parity kind: 00 none, 01 even, 10 odd |
| cfg_stop | input | 2 | Stop period: 00 one, 01 one and a half, 10 two bits |
| cfg_addr_mode | input | 1 | Ninth bit carries the address flag |
| baud_int | input | DIV_W | Integer part of the tick divisor, in clocks |
| baud_frac | input | FRAC_W | Fractional part of the tick divisor, in eighths |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_addr | input | 1 | Address flag sent with the byte in address mode |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |
| tx_line | output | 1 | Serial output, high when idle |
| rx_line | input | 1 | Serial input |
| rx_valid | output | 1 | One-clock strobe for a received character |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity mismatch on the reported character |
| rx_frame_err | output | 1 | Stop bit sampled low on the reported character |
| rx_addr_flag | output | 1 | Ninth bit of the reported character in address mode |

## Verification
The bench builds the block with its default parameters: a 16-bit integer divisor, a 3-bit fraction and a two-stage input synchroniser.

The bench sets the divisor at run time to 2 or 3 clocks per tick, with fractions of 0 and 4 eighths. At these settings a bit lasts 32 to 56 clocks, so many full frames of every length, parity and stop setting fit in a short run. A fraction of 4 eighths is the setting where the frame length visibly differs from the integer-only result. Comparing the two measured frame lengths shows whether the fractional stretch is applied.

// File: rtl/muart_pkg.sv
package muart_pkg;

    localparam int OVS      = 16;
    localparam int HALF_OVS = OVS / 2;
    localparam int TCNT_W   = 6;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSVD = 2'b11
    } par_e;

    typedef enum logic [1:0] {
        STP_ONE  = 2'b00,
        STP_HALF = 2'b01,
        STP_TWO  = 2'b10,
        STP_RSVD = 2'b11
    } stop_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_NINTH,
        S_STOP
    } ser_state_e;

    typedef struct packed {
        logic [1:0] len;
        par_e       par;
        stop_e      stop;
        logic       addr_mode;
    } frame_cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       addr;
    } rx_char_t;

    // keep only the configured number of low data bits
    function automatic logic [7:0] char_mask(input logic [7:0] d, input logic [1:0] len);
        logic [7:0] m;
        m = 8'hFF >> (2'd3 - len);
        return d & m;
    endfunction

    // index of the last data bit
    function automatic logic [2:0] last_idx(input logic [1:0] len);
        return 3'(len) + 3'd4;
    endfunction

    function automatic logic uses_parity(input par_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] len, input par_e p);
        logic x;
        x = ^char_mask(d, len);
        return (p == PAR_ODD) ? ~x : x;
    endfunction

    function automatic logic has_ninth(input logic addr_mode, input par_e p);
        return addr_mode || uses_parity(p);
    endfunction

    function automatic logic [TCNT_W-1:0] stop_ticks(input stop_e s);
        case (s)
            STP_ONE:  return TCNT_W'(OVS);
            STP_HALF: return TCNT_W'(OVS + HALF_OVS);
            default:  return TCNT_W'(2 * OVS);
        endcase
    endfunction

    // receiver fills from the top; move the character down to bit 0
    function automatic logic [7:0] align_rx(input logic [7:0] sh, input logic [1:0] len);
        return sh >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/muart_baud.sv
module muart_baud #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     limit;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic              tick_q;

    // the carry out of the phase accumulator stretches this period by one clock
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, div_frac};
        limit   = ((div_int == '0) ? CW'(1) : {1'b0, div_int}) + CW'(acc_sum[FRAC_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q >= limit - CW'(1)) begin
            cnt_q  <= '0;
            acc_q  <= acc_sum[FRAC_W-1:0];
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + CW'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/muart_tx.sv
module muart_tx
    import muart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       tx_addr,
    output logic       tx_ready,
    output logic       tx_line
);
    ser_state_e        state_q;
    frame_cfg_t        cfg_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic [TCNT_W-1:0] bit_last;
    logic [2:0]        bidx_q;
    logic [7:0]        sh_q;
    logic              ninth_q;
    logic              line_q;

    always_comb begin
        bit_last = (state_q == S_STOP) ? stop_ticks(cfg_q.stop) - TCNT_W'(1)
                                       : TCNT_W'(OVS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cfg_q   <= '0;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            sh_q    <= '0;
            ninth_q <= 1'b0;
            line_q  <= 1'b1;
        end else if (state_q == S_IDLE) begin
            line_q <= 1'b1;
            if (tx_valid) begin
                cfg_q   <= cfg;
                sh_q    <= tx_data;
                ninth_q <= cfg.addr_mode ? tx_addr : parity_bit(tx_data, cfg.len, cfg.par);
                tcnt_q  <= '0;
                bidx_q  <= '0;
                line_q  <= 1'b0;
                state_q <= S_START;
            end
        end else if (tick) begin
            if (tcnt_q == bit_last) begin
                tcnt_q <= '0;
                case (state_q)
                    S_START: begin
                        line_q  <= sh_q[0];
                        state_q <= S_DATA;
                    end
                    S_DATA: begin
                        if (bidx_q == last_idx(cfg_q.len)) begin
                            if (has_ninth(cfg_q.addr_mode, cfg_q.par)) begin
                                line_q  <= ninth_q;
                                state_q <= S_NINTH;
                            end else begin
                                line_q  <= 1'b1;
                                state_q <= S_STOP;
                            end
                        end else begin
                            bidx_q <= bidx_q + 3'd1;
                            sh_q   <= sh_q >> 1;
                            line_q <= sh_q[1];
                        end
                    end
                    S_NINTH: begin
                        line_q  <= 1'b1;
                        state_q <= S_STOP;
                    end
                    default: begin
                        line_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end
                endcase
            end else begin
                tcnt_q <= tcnt_q + TCNT_W'(1);
            end
        end
    end

    assign tx_ready = (state_q == S_IDLE);
    assign tx_line  = line_q;
endmodule

// File: rtl/muart_rx.sv
module muart_rx
    import muart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] cfg_len,
    input  par_e       cfg_par,
    input  logic       cfg_addr_mode,
    input  logic       rx_in,
    output logic       rx_valid,
    output rx_char_t   rx_char
);
    ser_state_e        state_q;
    logic [1:0]        len_q;
    par_e              par_q;
    logic              am_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic [2:0]        bidx_q;
    logic [7:0]        sh_q;
    logic              ninth_q;
    logic              valid_q;
    rx_char_t          char_q;
    logic [7:0]        aligned;
    logic              perr_now;

    always_comb begin
        aligned  = align_rx(sh_q, len_q);
        perr_now = !am_q && uses_parity(par_q) && (ninth_q != parity_bit(aligned, len_q, par_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            len_q   <= '0;
            par_q   <= PAR_NONE;
            am_q    <= 1'b0;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            sh_q    <= '0;
            ninth_q <= 1'b0;
            valid_q <= 1'b0;
            char_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            if (tick) begin
                case (state_q)
                    S_IDLE: begin
                        if (!rx_in) begin
                            len_q   <= cfg_len;
                            par_q   <= cfg_par;
                            am_q    <= cfg_addr_mode;
                            tcnt_q  <= '0;
                            state_q <= S_START;
                        end
                    end
                    S_START: begin
                        if (tcnt_q == TCNT_W'(HALF_OVS - 1)) begin
                            tcnt_q  <= '0;
                            bidx_q  <= '0;
                            state_q <= rx_in ? S_IDLE : S_DATA;
                        end else begin
                            tcnt_q <= tcnt_q + TCNT_W'(1);
                        end
                    end
                    default: begin
                        if (tcnt_q == TCNT_W'(OVS - 1)) begin
                            tcnt_q <= '0;
                            case (state_q)
                                S_DATA: begin
                                    sh_q <= {rx_in, sh_q[7:1]};
                                    if (bidx_q == last_idx(len_q)) begin
                                        state_q <= has_ninth(am_q, par_q) ? S_NINTH : S_STOP;
                                    end else begin
                                        bidx_q <= bidx_q + 3'd1;
                                    end
                                end
                                S_NINTH: begin
                                    ninth_q <= rx_in;
                                    state_q <= S_STOP;
                                end
                                default: begin
                                    valid_q      <= 1'b1;
                                    char_q.data  <= aligned;
                                    char_q.perr  <= perr_now;
                                    char_q.ferr  <= !rx_in;
                                    char_q.addr  <= am_q && ninth_q;
                                    state_q      <= S_IDLE;
                                end
                            endcase
                        end else begin
                            tcnt_q <= tcnt_q + TCNT_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    assign rx_valid = valid_q;
    assign rx_char  = char_q;
endmodule

// File: rtl/muart_core.sv
module muart_core
    import muart_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int FRAC_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_parity,
    input  logic [1:0]        cfg_stop,
    input  logic              cfg_addr_mode,
    input  logic [DIV_W-1:0]  baud_int,
    input  logic [FRAC_W-1:0] baud_frac,
    input  logic              tx_valid,
    input  logic [7:0]        tx_data,
    input  logic              tx_addr,
    output logic              tx_ready,
    output logic              tx_line,
    input  logic              rx_line,
    output logic              rx_valid,
    output logic [7:0]        rx_data,
    output logic              rx_par_err,
    output logic              rx_frame_err,
    output logic              rx_addr_flag
);
    frame_cfg_t cfg;
    logic       baud_tick;
    logic       rx_sync;
    rx_char_t   rx_char;

    always_comb begin
        cfg.len       = cfg_len;
        cfg.par       = par_e'(cfg_parity);
        cfg.stop      = stop_e'(cfg_stop);
        cfg.addr_mode = cfg_addr_mode;
    end

    // input synchroniser, resets to the idle level
    logic [SYNC_STAGES-1:0] sync_q;
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= rx_line;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
            end
        end
    endgenerate
    assign rx_sync = sync_q[SYNC_STAGES-1];

    muart_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) baud_i (
        .clk      (clk),
        .rst      (rst),
        .div_int  (baud_int),
        .div_frac (baud_frac),
        .tick     (baud_tick)
    );

    muart_tx tx_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .cfg      (cfg),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_addr  (tx_addr),
        .tx_ready (tx_ready),
        .tx_line  (tx_line)
    );

    muart_rx rx_i (
        .clk           (clk),
        .rst           (rst),
        .tick          (baud_tick),
        .cfg_len       (cfg.len),
        .cfg_par       (cfg.par),
        .cfg_addr_mode (cfg.addr_mode),
        .rx_in         (rx_sync),
        .rx_valid      (rx_valid),
        .rx_char       (rx_char)
    );

    assign rx_data      = rx_char.data;
    assign rx_par_err   = rx_char.perr;
    assign rx_frame_err = rx_char.ferr;
    assign rx_addr_flag = rx_char.addr;
endmodule

// File: rtl/muart_chk.sv
module muart_chk #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [DIV_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic [1:0]        cfg_parity,
    input logic              cfg_addr_mode,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_line,
    input logic              rx_valid,
    input logic              rx_par_err,
    input logic              rx_addr_flag
);
    localparam int GW = DIV_W + 2;

    logic [GW-1:0]     gap_q;
    logic [GW-1:0]     dmin;
    logic [DIV_W-1:0]  div_prev_q;
    logic [FRAC_W-1:0] frac_prev_q;
    logic              chg_q;
    logic              chg_now;

    always_comb begin
        dmin    = (div_int == '0) ? GW'(1) : GW'(div_int);
        chg_now = chg_q || (div_int != div_prev_q) || (div_frac != frac_prev_q);
    end

    // window counter: clocks since the previous tick
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q       <= '0;
            div_prev_q  <= '0;
            frac_prev_q <= '0;
            chg_q       <= 1'b1;
        end else begin
            div_prev_q  <= div_int;
            frac_prev_q <= div_frac;
            gap_q       <= tick ? GW'(1) : gap_q + GW'(1);
            if ((div_int != div_prev_q) || (div_frac != frac_prev_q)) chg_q <= 1'b1;
            else if (tick)                                             chg_q <= 1'b0;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_line && tx_ready && !rx_valid));

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> tx_line);

    p_accept_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !chg_now) |-> ((gap_q >= dmin) && (gap_q <= dmin + GW'(div_frac != '0))));

    p_noparity_clean_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_addr_mode && (cfg_parity == 2'b00 || cfg_parity == 2'b11)) |-> !rx_par_err);

    p_addr_noperr_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_addr_mode) |-> !rx_par_err);

    p_addr_off_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_addr_mode) |-> !rx_addr_flag);

    p_valid_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind muart_core muart_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .tick          (baud_tick),
    .div_int       (baud_int),
    .div_frac      (baud_frac),
    .cfg_parity    (cfg_parity),
    .cfg_addr_mode (cfg_addr_mode),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_line       (tx_line),
    .rx_valid      (rx_valid),
    .rx_par_err    (rx_par_err),
    .rx_addr_flag  (rx_addr_flag)
);

// File: tb/muart_core_tb_top.sv
module muart_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_len = 2'd3;
    logic [1:0]  cfg_parity = 2'd0;
    logic [1:0]  cfg_stop = 2'd0;
    logic        cfg_addr_mode = 1'b0;
    logic [15:0] baud_int = 16'd2;
    logic [2:0]  baud_frac = 3'd0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_addr = 1'b0;
    logic        tx_ready;
    logic        tx_line;
    logic        rx_line = 1'b1;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_par_err;
    logic        rx_frame_err;
    logic        rx_addr_flag;

    muart_core dut_i (
        .clk(clk), .rst(rst),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
        .cfg_addr_mode(cfg_addr_mode), .baud_int(baud_int), .baud_frac(baud_frac),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_addr(tx_addr),
        .tx_ready(tx_ready), .tx_line(tx_line), .rx_line(rx_line),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frame_err(rx_frame_err), .rx_addr_flag(rx_addr_flag)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // capture of receiver reports
    int         nvalid = 0;
    logic [7:0] cap_d;
    logic       cap_pe, cap_fe, cap_ad;
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            nvalid = nvalid + 1;
            cap_d  = rx_data;
            cap_pe = rx_par_err;
            cap_fe = rx_frame_err;
            cap_ad = rx_addr_flag;
        end
    end

    int cl = 3, cp = 0, cs = 0, D = 2, F = 0;
    bit ca = 1'b0;

    function automatic int bitclk();
        return 2 * (8 * D + F);
    endfunction

    function automatic bit expar(input logic [7:0] d, input int l, input int p);
        bit x = 1'b0;
        for (int i = 0; i < l + 5; i++) x ^= d[i];
        return (p == 2) ? ~x : x;
    endfunction

    function automatic logic [7:0] exmask(input logic [7:0] d, input int l);
        return d & (8'hFF >> (3 - l));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int l, input int p, input int s, input bit a, input int d, input int f);
        @(negedge clk);
        cl = l; cp = p; cs = s; ca = a; D = d; F = f;
        cfg_len = 2'(l); cfg_parity = 2'(p); cfg_stop = 2'(s);
        cfg_addr_mode = a; baud_int = 16'(d); baud_frac = 3'(f);
        repeat (4) @(negedge clk);
    endtask

    task automatic tx_frame(input logic [7:0] d, input bit a);
        int nb, st, t0, dur, expd, guard;
        bit h9, b9;
        nb = cl + 5;
        h9 = ca || cp == 1 || cp == 2;
        b9 = ca ? a : expar(d, cl, cp);
        st = (cs == 0) ? 16 : (cs == 1) ? 24 : 32;
        @(negedge clk);
        tx_valid = 1'b1; tx_data = d; tx_addr = a;
        @(negedge clk);
        tx_valid = 1'b0;
        t0 = cyc;
        chk(tx_line == 1'b0, "R2 start bit low", tx_line, 0);
        chk(tx_ready == 1'b0, "R4 ready low in frame", tx_ready, 0);
        repeat (bitclk() / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            repeat (bitclk()) @(negedge clk);
            chk(tx_line == d[i], "R2 data bit lsb first", tx_line, d[i]);
        end
        if (h9) begin
            repeat (bitclk()) @(negedge clk);
            if (ca) chk(tx_line == b9, "R5 address bit", tx_line, b9);
            else    chk(tx_line == b9, "R3 parity bit", tx_line, b9);
        end
        repeat (bitclk()) @(negedge clk);
        chk(tx_line == 1'b1, "R4 stop bit high", tx_line, 1);
        guard = 0;
        while (!tx_ready && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        dur  = cyc - t0;
        expd = ((16 * (1 + nb + int'(h9)) + st) * (8 * D + F)) / 8;
        chk(dur <= expd + 1 && dur >= expd - D - 2, "R4 R6 frame length in clocks", dur, expd);
        chk(tx_line == 1'b1, "R1 idle line high", tx_line, 1);
    endtask

    task automatic drive_bit(input bit v, input int clocks);
        rx_line = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit b9, input bit stop_ok);
        int n0, nb;
        bit h9, pe;
        nb = cl + 5;
        h9 = ca || cp == 1 || cp == 2;
        n0 = nvalid;
        @(negedge clk);
        drive_bit(1'b0, bitclk());
        for (int i = 0; i < nb; i++) drive_bit(d[i], bitclk());
        if (h9) drive_bit(b9, bitclk());
        if (stop_ok) drive_bit(1'b1, bitclk());
        else begin
            drive_bit(1'b0, (3 * bitclk()) / 4);
            drive_bit(1'b1, bitclk());
        end
        drive_bit(1'b1, 2 * bitclk());
        pe = !ca && (cp == 1 || cp == 2) && (b9 != expar(d, cl, cp));
        chk(nvalid == n0 + 1, "R12 one valid strobe per character", nvalid - n0, 1);
        chk(cap_d == exmask(d, cl), "R7 received data", cap_d, exmask(d, cl));
        chk(cap_pe == pe, "R8 parity error flag", cap_pe, pe);
        chk(cap_fe == !stop_ok, "R9 framing error flag", cap_fe, !stop_ok);
        chk(cap_ad == (ca && b9), "R10 address flag", cap_ad, ca && b9);
    endtask

    initial begin
        void'($urandom(32'h1D5E_ED01));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_line == 1'b1, "R1 reset tx line", tx_line, 1);
        chk(tx_ready == 1'b1, "R1 reset ready", tx_ready, 1);
        chk(rx_valid == 1'b0, "R1 reset rx valid", rx_valid, 0);

        // directed transmit corners
        set_cfg(3, 0, 0, 1'b0, 2, 0);  tx_frame(8'hA5, 1'b0);
        set_cfg(0, 1, 1, 1'b0, 2, 0);  tx_frame(8'hF3, 1'b0);
        set_cfg(2, 2, 2, 1'b0, 2, 0);  tx_frame(8'h55, 1'b0);
        set_cfg(3, 1, 0, 1'b1, 2, 0);  tx_frame(8'h81, 1'b1);
        set_cfg(3, 2, 1, 1'b1, 2, 0);  tx_frame(8'h7E, 1'b0);
        // R6 fractional divisor against integer-only
        set_cfg(3, 0, 0, 1'b0, 3, 0);  tx_frame(8'h3C, 1'b0);
        set_cfg(3, 0, 0, 1'b0, 3, 4);  tx_frame(8'h3C, 1'b0);
        set_cfg(1, 1, 2, 1'b0, 3, 4);  tx_frame(8'hC9, 1'b0);

        // directed receive corners
        set_cfg(3, 0, 0, 1'b0, 2, 0);  rx_frame(8'h96, 1'b0, 1'b1);
        set_cfg(0, 0, 0, 1'b0, 2, 0);  rx_frame(8'hFF, 1'b0, 1'b1);
        set_cfg(3, 1, 0, 1'b0, 2, 0);  rx_frame(8'h07, ~expar(8'h07, 3, 1), 1'b1);
        set_cfg(2, 2, 0, 1'b0, 2, 0);  rx_frame(8'h5A, expar(8'h5A, 2, 2), 1'b1);
        set_cfg(3, 0, 0, 1'b0, 2, 0);  rx_frame(8'h42, 1'b0, 1'b0);
        set_cfg(3, 1, 0, 1'b1, 2, 0);  rx_frame(8'h12, 1'b1, 1'b1);
        set_cfg(3, 1, 0, 1'b1, 2, 0);  rx_frame(8'h13, 1'b0, 1'b1);
        set_cfg(3, 0, 0, 1'b0, 3, 4);  rx_frame(8'hB4, 1'b0, 1'b1);

        // R11 short low pulse is rejected
        begin
            int n0;
            set_cfg(3, 0, 0, 1'b0, 2, 0);
            n0 = nvalid;
            drive_bit(1'b0, bitclk() / 4);
            drive_bit(1'b1, 14 * bitclk());
            chk(nvalid == n0, "R11 glitch not a start bit", nvalid - n0, 0);
        end

        // constrained random frames in both directions
        for (int k = 0; k < 30; k++) begin
            int l, p, s;
            bit a;
            l = int'($urandom_range(0, 3));
            p = int'($urandom_range(0, 2));
            s = int'($urandom_range(0, 2));
            a = 1'($urandom_range(0, 1));
            set_cfg(l, p, s, a, 2, 0);
            tx_frame(8'($urandom()), 1'($urandom_range(0, 1)));
        end
        for (int k = 0; k < 30; k++) begin
            int l, p;
            bit a, b9;
            logic [7:0] d;
            l = int'($urandom_range(0, 3));
            p = int'($urandom_range(0, 2));
            a = 1'($urandom_range(0, 1));
            d = 8'($urandom());
            set_cfg(l, p, 0, a, 2, 0);
            if (a) b9 = 1'($urandom_range(0, 1));
            else if (p != 0) b9 = ($urandom_range(0, 3) == 0) ? ~expar(d, l, p) : expar(d, l, p);
            else b9 = 1'b0;
            rx_frame(d, b9, 1'b1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule